// File: doc/BRIEF.md
# GPIO Pin Interrupt Unit

This block watches a bank of general-purpose input pins and raises a single interrupt request when any pin sees the condition software selected for it. Each pin can fire on a rising edge, a falling edge, any transition, a high level or a low level. A fired condition sets that pin's status bit. A per-pin mask decides whether the status bit reaches the request line.

The pins enter through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. Edge status bits are latched and cleared by writing one. Level status bits follow the live input. The mask cannot be written directly: one register clears mask bits and another sets them, both acting only on the bits written as one.

The request output is registered. It also ORs in a chain input, so that the requests of several banks can be merged into one line. Software reaches every register through a plain write/read port with a registered read path.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every pin is masked, every status bit is 0, every pin is set to level mode (edge-select 0) with polarity 1, the both-edge register is 0, and `irq_out` is 0.
- R2: Writing 1 to a bit of the unmask register clears that mask bit. Writing 1 to a bit of the mask-set register sets it. Bits written as 0 keep their mask value, and no other write changes the mask.
- R3: Register offsets are 0 for the mask (read-only), 1 for unmask, 2 for mask-set, 3 for status (write one to clear, reads the status bits), 4 for edge-select, 5 for polarity and 6 for both-edge. Reads of offsets 1 and 2 return 0. Read data appears on `reg_rdata` at the clock edge that samples `reg_re`.
- R4: In level mode (edge-select bit 0) the status bit equals the pin's active level: high when polarity is 1, low when it is 0. The both-edge bit and writes to status have no effect on it.
- R5: In edge mode (edge-select 1, both-edge 0), a polarity of 1 sets status on a rising edge and a polarity of 0 sets it on a falling edge. Status stays set until it is cleared, and the opposite edge does not set it.
- R6: In edge mode with both-edge set to 1, any transition of the pin sets its status bit, whatever the polarity.
- R7: Writing 1 to a status bit that holds a latched edge clears it. Writing 0 leaves it unchanged.
- R8: When a new edge event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: A masked pin still sets and holds its status bit. The request rises once the pin is unmasked, unless the bit was cleared first.
- R10: `irq_out` is the registered OR, over all pins, of status AND NOT mask, ORed with `irq_chain_in`. It follows its inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | NUM_PINS | Write data, one bit per pin |
| reg_rdata | output | NUM_PINS | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| irq_chain_in | input | 1 | Request from another bank, merged into the output |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The assertions are checked on every cycle. They check that the request is the registered OR of the unmasked status and the chain input, and that the mask moves only on writes to the two mask-control offsets. They also check that a latched edge bit never drops without a clear, that level-mode status tracks the synchronised pin through its polarity, and that the unmask and mask-set offsets read as zero. Only the bench's scenarios can show the rest. That covers which edge of which polarity sets a bit, and that a write of zero to status has no effect. It also covers that an event wins a same-cycle clear, and that a bit latched while masked raises the request once the pin is unmasked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_MASK      = 3'd0,
    RA_UNMASK    = 3'd1,
    RA_MASK_SET  = 3'd2,
    RA_STATUS    = 3'd3,
    RA_EDGE_SEL  = 3'd4,
    RA_POLARITY  = 3'd5,
    RA_BOTH_EDGE = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  input  logic [NUM_PINS-1:0] edge_sel_i,
  input  logic [NUM_PINS-1:0] polarity_i,
  input  logic [NUM_PINS-1:0] both_edge_i,
  output logic [NUM_PINS-1:0] event_o,
  output logic [NUM_PINS-1:0] level_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_sync_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, chosen;
    assign rise   = pin_sync_i[i] & ~prev_q[i];
    assign fall   = ~pin_sync_i[i] & prev_q[i];
    assign chosen = both_edge_i[i] ? (rise | fall) : (polarity_i[i] ? rise : fall);
    assign event_o[i] = edge_sel_i[i] & chosen;
    assign level_o[i] = ~edge_sel_i[i] & ~(pin_sync_i[i] ^ polarity_i[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0]   event_i,
  input  logic [NUM_PINS-1:0]   level_i,
  output logic [NUM_PINS-1:0]   status_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   edge_sel_o,
  output logic [NUM_PINS-1:0]   polarity_o,
  output logic [NUM_PINS-1:0]   both_edge_o
);
  logic [NUM_PINS-1:0] status_q, mask_q, edge_q, pol_q, both_q, clr_vec, status_d;

  assign clr_vec = (we_i && addr_i == RA_STATUS) ? wdata_i : '0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_stat
    assign status_d[i] = edge_q[i] ? ((status_q[i] & ~clr_vec[i]) | event_i[i])
                                   : level_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      edge_q   <= '0;
      pol_q    <= '1;
      both_q   <= '0;
    end else begin
      status_q <= status_d;
      if (we_i) begin
        case (addr_i)
          RA_UNMASK:    mask_q <= mask_q & ~wdata_i;
          RA_MASK_SET:  mask_q <= mask_q | wdata_i;
          RA_EDGE_SEL:  edge_q <= wdata_i;
          RA_POLARITY:  pol_q  <= wdata_i;
          RA_BOTH_EDGE: both_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (re_i) begin
      case (addr_i)
        RA_MASK:      rdata_o <= mask_q;
        RA_STATUS:    rdata_o <= status_q;
        RA_EDGE_SEL:  rdata_o <= edge_q;
        RA_POLARITY:  rdata_o <= pol_q;
        RA_BOTH_EDGE: rdata_o <= both_q;
        default:      rdata_o <= '0;
      endcase
    end
  end

  assign status_o    = status_q;
  assign mask_o      = mask_q;
  assign edge_sel_o  = edge_q;
  assign polarity_o  = pol_q;
  assign both_edge_o = both_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  output logic [NUM_PINS-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  irq_chain_in,
  output logic                  irq_out
);
  logic [NUM_PINS-1:0] pin_sync, event_vec, level_vec;
  logic [NUM_PINS-1:0] status_vec, mask_vec, edge_vec, pol_vec, both_vec;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(pin_sync)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .pin_sync_i(pin_sync),
    .edge_sel_i(edge_vec), .polarity_i(pol_vec), .both_edge_i(both_vec),
    .event_o(event_vec), .level_o(level_vec)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .re_i(reg_re), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .event_i(event_vec), .level_i(level_vec),
    .status_o(status_vec), .mask_o(mask_vec),
    .edge_sel_o(edge_vec), .polarity_o(pol_vec), .both_edge_o(both_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= (|(status_vec & ~mask_vec)) | irq_chain_in;
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic                  reg_re,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [NUM_PINS-1:0]   reg_wdata,
  input logic [NUM_PINS-1:0]   reg_rdata,
  input logic                  irq_chain_in,
  input logic                  irq_out,
  input logic [NUM_PINS-1:0]   status_vec,
  input logic [NUM_PINS-1:0]   mask_vec,
  input logic [NUM_PINS-1:0]   edge_vec,
  input logic [NUM_PINS-1:0]   pol_vec,
  input logic [NUM_PINS-1:0]   pin_sync
);
  logic [NUM_PINS-1:0] clr_vec;
  logic mask_write;
  assign clr_vec    = (reg_we && reg_addr == RA_STATUS) ? reg_wdata : '0;
  assign mask_write = reg_we && (reg_addr == RA_UNMASK || reg_addr == RA_MASK_SET);

  assert_irq_merge_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past((|(status_vec & ~mask_vec)) | irq_chain_in));

  assert_mask_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !mask_write |=> $stable(mask_vec));

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(status_vec & edge_vec & ~clr_vec) & ~status_vec) == '0);

  assert_level_track_R4: assert property (@(posedge clk) disable iff (rst)
    ((status_vec ^ $past(~(pin_sync ^ pol_vec))) & $past(~edge_vec)) == '0);

  assert_ctrl_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_re && (reg_addr == RA_UNMASK || reg_addr == RA_MASK_SET)) |=> reg_rdata == '0);
endmodule

bind gpio_irq_unit gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_checker (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_chain_in(irq_chain_in),
  .irq_out(irq_out), .status_vec(status_vec), .mask_vec(mask_vec),
  .edge_vec(edge_vec), .pol_vec(pol_vec), .pin_sync(pin_sync)
);

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [NP-1:0] reg_wdata = '0, reg_rdata, pin_in = '0;
  logic irq_chain_in = 1'b0, irq_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [NP-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit #(.NUM_PINS(NP)) i_gpio_irq_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .irq_chain_in(irq_chain_in), .irq_out(irq_out)
  );

  // Monitor: read data is valid at the negedge after the sampling edge.
  always @(posedge clk) rd_seen <= reg_re;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [NP-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [NP-1:0] e, input string t);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_tests++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s: irq_out=%b expected=%b", t, irq_out, e);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, 8'hFF, "R1 mask");
    rd(3'd3, 8'h00, "R1 status");
    rd(3'd4, 8'h00, "R1 edge-select");
    rd(3'd5, 8'hFF, "R1 polarity");
    rd(3'd6, 8'h00, "R1 both-edge");
    chk_irq(1'b0, "R1 irq");
    // R2 mask control, R3 control reads
    wr(3'd1, 8'h05); rd(3'd0, 8'hFA, "R2 unmask");
    wr(3'd2, 8'h01); rd(3'd0, 8'hFB, "R2 mask-set");
    wr(3'd1, 8'h00); rd(3'd0, 8'hFB, "R2 zero write");
    wr(3'd0, 8'h00); rd(3'd0, 8'hFB, "R2 mask read-only");
    rd(3'd1, 8'h00, "R3 unmask reads zero");
    rd(3'd2, 8'h00, "R3 mask-set reads zero");
    // R4 level mode, active high
    pin_in[2] = 1'b1; settle();
    rd(3'd3, 8'h04, "R4 level high");
    chk_irq(1'b1, "R10 level irq");
    wr(3'd3, 8'h04); settle();
    rd(3'd3, 8'h04, "R4 clear ignored");
    pin_in[2] = 1'b0; settle();
    rd(3'd3, 8'h00, "R4 level released");
    chk_irq(1'b0, "R10 irq drops");
    // R4 active low, both-edge ignored
    wr(3'd5, 8'hFB); settle();
    rd(3'd3, 8'h04, "R4 active low");
    wr(3'd6, 8'h04); settle();
    rd(3'd3, 8'h04, "R4 both-edge ignored");
    pin_in[2] = 1'b1; settle();
    rd(3'd3, 8'h00, "R4 active low released");
    wr(3'd6, 8'h00); wr(3'd5, 8'hFF);
    pin_in = '0; settle();
    // R5 edge mode
    wr(3'd4, 8'hFF); settle();
    rd(3'd3, 8'h00, "R5 edge start");
    pin_in[0] = 1'b1; settle();
    rd(3'd3, 8'h01, "R5 rising sets");
    pin_in[0] = 1'b0; settle();
    rd(3'd3, 8'h01, "R5 latched after fall");
    // R7 clear
    wr(3'd3, 8'h00); rd(3'd3, 8'h01, "R7 zero write");
    wr(3'd3, 8'h01); rd(3'd3, 8'h00, "R7 one clears");
    // R5 falling
    wr(3'd5, 8'hFD);
    pin_in[1] = 1'b1; settle();
    rd(3'd3, 8'h00, "R5 falling ignores rise");
    pin_in[1] = 1'b0; settle();
    rd(3'd3, 8'h02, "R5 falling sets");
    wr(3'd3, 8'h02);
    // R6 both edges
    wr(3'd6, 8'h10);
    pin_in[4] = 1'b1; settle();
    rd(3'd3, 8'h10, "R6 rise");
    wr(3'd3, 8'h10); rd(3'd3, 8'h00, "R6 cleared");
    pin_in[4] = 1'b0; settle();
    rd(3'd3, 8'h10, "R6 fall");
    wr(3'd3, 8'h10);
    // R9 masked pin
    pin_in[6] = 1'b1; settle();
    rd(3'd3, 8'h40, "R9 masked status held");
    chk_irq(1'b0, "R9 masked no irq");
    wr(3'd1, 8'h40); repeat (2) @(negedge clk);
    chk_irq(1'b1, "R9 irq on unmask");
    wr(3'd3, 8'h40); repeat (2) @(negedge clk);
    chk_irq(1'b0, "R9 irq after clear");
    wr(3'd2, 8'h40);
    // R10 chain input
    irq_chain_in = 1'b1; @(negedge clk);
    chk_irq(1'b1, "R10 chain in");
    irq_chain_in = 1'b0; @(negedge clk);
    chk_irq(1'b0, "R10 chain released");
    // R8 event and clear in the same cycle
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd3, 8'h01);
    rd(3'd3, 8'h01, "R8 event wins");
    wr(3'd3, 8'h01); rd(3'd3, 8'h00, "R8 later clear");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule